// File: doc/BRIEF.md
# Single-Register I2C Target

This block is an I2C target that gives a host access to one 8-bit control and status register. No sub-address byte is used. The register is reached straight from the device address. A write transfer loads the six control bits, and those bits leave the block as a parallel output. A read transfer returns the whole byte. The two top bits of that byte are read-only diagnostic flags taken live from two status inputs.

SCL and SDA are sampled by a fast system clock through two-flop synchronisers. All bus events (START, STOP, clock edges) are found on the synchronised copies. The block drives SDA only through an open-drain pull-down enable. A two-bit strap input picks one of four device addresses.

A supply-lockout input clears the register and holds it at zero. While the lockout is asserted, the target acknowledges nothing.

Top module: `i2cr_target`

## Requirements
- R1: The first byte after a START carries the 7-bit device address in its upper seven bits and the direction in bit 0 (1 = read, 0 = write). On a match, the target acknowledges by pulling SDA low during the ninth clock.
- R2: Every byte is 8 bits long and is sent MSB first. Each byte is followed by an acknowledge slot on the ninth clock.
- R3: The device address is 7'b0001000 with the strap code placed in address bits [1:0], which gives 0x08 to 0x0B. A transfer to any other address is not acknowledged and leaves the register unchanged.
- R4: Register layout: bits [5:0] are the writable control bits, driven on `ctrl_out`. Bit 6 reflects `flag_ovl` and bit 7 reflects `flag_ovt`. A data byte written to the target loads bits [5:0] only. Bits 7 and 6 of the written byte have no effect.
- R5: After reset, `ctrl_out` is 0 and `sda_oe` is 0.
- R6: While `lockout` is high, `ctrl_out` is 0 from the next cycle on. No address is acknowledged, and written data is discarded.
- R7: A read returns {flag_ovt, flag_ovl, ctrl_out}, MSB first. If the host acknowledges, the same register byte is sent again. If the host does not acknowledge, the target releases SDA and stays quiet until the next START.
- R8: A START that arrives in the middle of a byte abandons the current transfer and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled I2C clock line |
| sda_in | input | 1 | Sampled I2C data line |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_strap | input | 2 | Selects the low two address bits |
| lockout | input | 1 | Supply lockout: clears the register and silences the target |
| flag_ovl | input | 1 | Overload status, read back in bit 6 |
| flag_ovt | input | 1 | Over-temperature status, read back in bit 7 |
| ctrl_out | output | 6 | Writable control bits |

## Verification
The hardest case to reach from the ports is a START that lands in the middle of a byte. The engine must then drop a partly shifted byte and its bit count, with no STOP in between. The bench reaches this case by clocking out only a few address bits and then raising SDA while SCL is low. It then raises SCL and lowers SDA to form a new START. A full addressed write follows, and the bench checks that this write is acknowledged and stored. The address sweep crosses every strap code with every address in the strap range, plus one address outside it. Read-back with repeated host acknowledges runs under all four flag combinations.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int BYTE_W = 8;
    localparam int CTRL_W = 6;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic [6:0] make_addr(input logic [6:0] base, input logic [1:0] strap);
        return {base[6:2], strap};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_reg(input logic ovt, input logic ovl,
                                                  input logic [CTRL_W-1:0] ctrl);
        return {ovt, ovl, ctrl};
    endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2cr_events.sv
module i2cr_events
    import i2cr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lockout,
    input  bus_ev_t           ev,
    input  logic [6:0]        dev_addr,
    input  logic              flag_ovl,
    input  logic              flag_ovt,
    output logic              sda_oe,
    output logic [CTRL_W-1:0] ctrl
);
    eng_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              addr_phase;
    logic              rd_mode;
    logic              host_ack;
    logic [BYTE_W-1:0] reg_byte;

    assign reg_byte = pack_reg(flag_ovt, flag_ovl, ctrl);

    always_ff @(posedge clk) begin
        if (rst || lockout) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            txreg      <= '0;
            addr_phase <= 1'b0;
            rd_mode    <= 1'b0;
            host_ack   <= 1'b0;
            ctrl       <= '0;
        end else if (ev.start) begin
            state      <= ST_RX;
            cnt        <= '0;
            addr_phase <= 1'b1;
        end else if (ev.stop) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RX: begin
                    if (ev.scl_rise && cnt < CNT_W'(BYTE_W)) begin
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (ev.scl_fall && cnt == CNT_W'(BYTE_W)) begin
                        if (addr_phase) begin
                            if (shreg[BYTE_W-1:1] == dev_addr) begin
                                state   <= ST_ACK;
                                rd_mode <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            ctrl  <= shreg[CTRL_W-1:0];
                            state <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rd_mode) begin
                            state <= ST_TX;
                            txreg <= reg_byte;
                        end else begin
                            state      <= ST_RX;
                            addr_phase <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            state <= ST_HACK;
                            cnt   <= '0;
                        end else begin
                            txreg <= {txreg[BYTE_W-2:0], 1'b0};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                end
                ST_HACK: begin
                    if (ev.scl_rise) host_ack <= ~ev.sda;
                    if (ev.scl_fall) begin
                        if (host_ack) begin
                            state <= ST_TX;
                            txreg <= reg_byte;
                            cnt   <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = (state == ST_ACK) || (state == ST_TX && !txreg[BYTE_W-1]);

    assert_lockout_clear_R6: assert property (@(posedge clk) disable iff (rst)
        lockout |=> (ctrl == '0 && state == ST_IDLE));

    assert_start_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !lockout) |=> (state == ST_RX && cnt == '0 && addr_phase));

    assert_bit_count_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(BYTE_W));

    assert_tx_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX && $past(state) != ST_TX) |->
            ($past(state) == ST_ACK || $past(state) == ST_HACK));

    assert_ctrl_write_only_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl != $past(ctrl)) |->
            ($past(lockout) || ($past(state) == ST_RX && !$past(addr_phase))));

    assert_ack_after_byte_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && $past(state) == ST_RX) |-> $past(cnt) == CNT_W'(BYTE_W));

endmodule

// File: rtl/i2cr_target.sv
module i2cr_target
    import i2cr_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR   = 7'b0001000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [1:0]        addr_strap,
    input  logic              lockout,
    input  logic              flag_ovl,
    input  logic              flag_ovt,
    output logic [CTRL_W-1:0] ctrl_out
);
    logic [1:0] line_s;
    bus_ev_t    ev;
    logic [6:0] dev_addr;

    assign dev_addr = make_addr(BASE_ADDR, addr_strap);

    i2cr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (line_s)
    );

    i2cr_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_s (line_s[1]),
        .sda_s (line_s[0]),
        .ev    (ev)
    );

    i2cr_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .lockout  (lockout),
        .ev       (ev),
        .dev_addr (dev_addr),
        .flag_ovl (flag_ovl),
        .flag_ovt (flag_ovt),
        .sda_oe   (sda_oe),
        .ctrl     (ctrl_out)
    );
endmodule

// File: tb/sim_i2cr_target.sv
module sim_i2cr_target;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_oe;
    logic [1:0] strap = 2'd0;
    logic       lockout = 1'b0;
    logic       ovl = 1'b0;
    logic       ovt = 1'b0;
    logic [5:0] ctrl_out;
    logic       sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    i2cr_target u0 (
        .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_line), .sda_oe(sda_oe),
        .addr_strap(strap), .lockout(lockout), .flag_ovl(ovl), .flag_ovt(ovt),
        .ctrl_out(ctrl_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b;    tick(Q);
        scl_drv = 1'b1; tick(2 * Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        b = sda_line;   tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit host_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!host_ack);
        sda_drv = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, output bit a_ack);
        bit dk;
        bus_start();
        send_byte({a, 1'b0}, a_ack);
        if (a_ack) send_byte(d, dk);
        bus_stop();
        tick(Q);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        bit         ak;
        logic [7:0] rb;
        logic [6:0] exp_ctrl;

        tick(5);
        rst = 1'b0;
        tick(5);
        // R5 reset state
        check(ctrl_out == 6'd0, "R5 ctrl after reset", ctrl_out, 0);
        check(sda_oe == 1'b0, "R5 sda_oe after reset", sda_oe, 0);

        // R1 R3 strap x address sweep, plus one address outside the range
        exp_ctrl = 7'd0;
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int a = 7; a < 12; a++) begin
                logic [7:0] dv;
                bit         hit;
                dv  = 8'((s * 16 + a * 5 + 3) & 8'h3f);
                hit = (a == 8 + s);
                do_write(7'(a), dv, ak);
                check(ak == hit, "R3 address ack", ak, hit);
                if (hit) exp_ctrl = {1'b0, dv[5:0]};
                check(ctrl_out == exp_ctrl[5:0], "R3 ctrl after write", ctrl_out, exp_ctrl[5:0]);
            end
        end

        // R4 upper data bits have no effect; R2 data sweep with MSB-first patterns
        strap = 2'd2;
        for (int k = 0; k < 16; k++) begin
            logic [7:0] dv;
            dv = 8'((k * 37 + 11) & 8'hff) | 8'hc0;
            do_write(7'h0a, dv, ak);
            check(ak, "R1 address ack sweep", ak, 1);
            check(ctrl_out == dv[5:0], "R4 R2 write loads low six bits", ctrl_out, dv[5:0]);
            exp_ctrl = {1'b0, dv[5:0]};
        end

        // R7 reads under all flag combinations, repeated on host ack
        for (int f = 0; f < 4; f++) begin
            logic [7:0] expv;
            ovl = f[0];
            ovt = f[1];
            expv = {ovt, ovl, exp_ctrl[5:0]};
            bus_start();
            send_byte({7'h0a, 1'b1}, ak);
            check(ak, "R1 read address ack", ak, 1);
            recv_byte(rb, 1'b1);
            check(rb == expv, "R7 R4 first read byte", rb, expv);
            recv_byte(rb, 1'b1);
            check(rb == expv, "R7 repeated read byte", rb, expv);
            recv_byte(rb, 1'b0);
            check(rb == expv, "R7 last read byte", rb, expv);
            tick(Q);
            check(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
            bus_stop();
            tick(Q);
        end

        // R8 START in the middle of the address byte
        bus_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte({7'h0a, 1'b0}, ak);
        check(ak, "R8 ack after restarted address", ak, 1);
        send_byte(8'h15, ak);
        bus_stop();
        tick(Q);
        check(ctrl_out == 6'h15, "R8 write after restart", ctrl_out, 6'h15);

        // R8 START in the middle of a data byte
        bus_start();
        send_byte({7'h0a, 1'b0}, ak);
        put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte({7'h0a, 1'b0}, ak);
        send_byte(8'h2a, ak);
        bus_stop();
        tick(Q);
        check(ctrl_out == 6'h2a, "R8 data byte aborted then rewritten", ctrl_out, 6'h2a);

        // R6 lockout
        lockout = 1'b1;
        tick(2);
        check(ctrl_out == 6'd0, "R6 lockout clears register", ctrl_out, 0);
        do_write(7'h0a, 8'h3f, ak);
        check(!ak, "R6 no ack under lockout", ak, 0);
        check(ctrl_out == 6'd0, "R6 register held at zero", ctrl_out, 0);
        lockout = 1'b0;
        tick(Q);
        check(ctrl_out == 6'd0, "R6 zero after lockout release", ctrl_out, 0);
        do_write(7'h0a, 8'h07, ak);
        check(ak && ctrl_out == 6'h07, "R6 usable after release", ctrl_out, 6'h07);

        finish_run();
    end
endmodule